// File: doc/BRIEF.md
# Bus-Master DMA Channel Register Set

This block is the host-facing register window of one bus-master storage DMA channel. The host uses it to arm and disarm a transfer, pick its direction, point the channel at a descriptor table in memory, and watch its progress. The block does not walk descriptors itself. It gives a separate walker a one-cycle start request and a one-cycle pointer reload request, and it exposes the table base address for that reload. The walker later reports completion, and optionally an error, back to this block.

The window is eight bytes wide. The control byte is at offset 0 and the state byte at offset 2. Offsets 4 to 7 hold the table base, which may be accessed as a byte, a halfword or a word in little-endian lane order. Arming happens only when the run bit actually changes. Disarming never cuts a transfer short: the busy flag stays set until the walker says it has finished. The drive interrupt is passed straight through to the host, and a rising level on it is also captured as a sticky flag.

Top module: `bm_dma_regs`

## Requirements
- R1: While rst_ni is low and after it, the control byte, state byte, table base and busy flag all read zero, and no request pulse is raised.
- R2: A control write (offset 0) keeps only bit 0 (run) and bit 3 (direction, driven on dir_o). All other written bits read back as zero. Direction updates on every control write.
- R3: A control write whose bit 0 equals the stored run bit raises neither start_pulse_o nor reload_o.
- R4: A 0-to-1 change of the run bit while idle raises reload_o and start_pulse_o for exactly the one cycle after the write edge, and sets the busy flag (active_o, state bit 0) at that same edge.
- R5: A 0-to-1 change of the run bit while still busy raises reload_o but not start_pulse_o.
- R6: A 1-to-0 change of the run bit leaves the busy flag set. Only done_i clears it, at the clock edge where done_i is sampled high.
- R7: A table-base write merges only the addressed lanes. Size codes are 0 = byte, 1 = halfword, 2 = word. The lane offset is acc_off_i minus 4. Bits 1:0 of the stored base are always zero.
- R8: A table-base read returns the base shifted right by 8 times the lane offset and masked to the access width.
- R9: irq_o equals irq_i at all times. irq_i sampled high sets state bit 2, and that bit stays set after irq_i falls.
- R10: Writing 1 to state bit 2 or bit 1 clears that bit. err_i sampled high sets bit 1. State bit 0 cannot be changed by a host write.
- R11: When a set source (irq_i or err_i) and a write-1-to-clear of the same bit occur in the same cycle, the bit remains set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| acc_en_i | input | 1 | Host access strobe |
| acc_we_i | input | 1 | Access is a write |
| acc_off_i | input | 3 | Byte offset within the window |
| acc_size_i | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| acc_wdata_i | input | 32 | Write data, lane-aligned to the offset |
| acc_rdata_o | output | 32 | Read data for the addressed register |
| done_i | input | 1 | Walker reports transfer finished |
| err_i | input | 1 | Walker reports an error |
| irq_i | input | 1 | Drive interrupt level |
| irq_o | output | 1 | Interrupt forwarded to the host |
| start_pulse_o | output | 1 | One-cycle start request to the walker |
| reload_o | output | 1 | One-cycle request to reload the fetch pointer |
| table_base_o | output | 32 | Descriptor table base address |
| dir_o | output | 1 | Transfer direction bit |
| active_o | output | 1 | Channel busy flag |

## Verification
The hardest state to reach is a re-arm while a transfer is still outstanding. That is the only case where reload and start separate. The bench gets there by arming, disarming without raising done_i, and arming again, so the busy flag is still set when the run bit rises a second time. The set-versus-clear collision on the state bits is the other awkward case. The bench reaches it by holding irq_i high across the write-1-to-clear access.

// File: rtl/bm_dma_pkg.sv
package bm_dma_pkg;
  localparam int unsigned OFF_W = 3;
  localparam logic [OFF_W-1:0] OFF_CMD = 3'd0;
  localparam logic [OFF_W-1:0] OFF_STS = 3'd2;

  localparam int unsigned CMD_RUN = 0;
  localparam int unsigned CMD_DIR = 3;
  localparam logic [7:0] CMD_KEEP = 8'h09;

  localparam int unsigned STS_ACT = 0;
  localparam int unsigned STS_ERR = 1;
  localparam int unsigned STS_INT = 2;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;
endpackage

// File: rtl/bm_cmd_ctrl.sv
module bm_cmd_ctrl
  import bm_dma_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  input  logic       done_i,
  output logic [7:0] cmd_o,
  output logic       active_o,
  output logic       start_pulse_o,
  output logic       reload_o
);
  logic [7:0] cmd_q;
  logic       active_q, start_q, reload_q;
  logic       run_rise;

  // only an actual change of the run bit counts
  assign run_rise = wr_i && wdata_i[CMD_RUN] && !cmd_q[CMD_RUN];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q    <= '0;
      active_q <= 1'b0;
      start_q  <= 1'b0;
      reload_q <= 1'b0;
    end else begin
      if (wr_i) cmd_q <= wdata_i & CMD_KEEP;
      reload_q <= run_rise;
      start_q  <= run_rise && !active_q;
      // a falling run bit never clears busy: wait for the walker
      if (run_rise && !active_q) active_q <= 1'b1;
      else if (done_i)           active_q <= 1'b0;
    end
  end

  assign cmd_o         = cmd_q;
  assign active_o      = active_q;
  assign start_pulse_o = start_q;
  assign reload_o      = reload_q;
endmodule

// File: rtl/bm_status_bits.sv
module bm_status_bits
  import bm_dma_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  input  logic       active_i,
  input  logic       err_set_i,
  input  logic       irq_set_i,
  output logic [7:0] sts_o
);
  logic err_q, int_q;

  // set sources win over write-one-to-clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q <= 1'b0;
      int_q <= 1'b0;
    end else begin
      err_q <= err_set_i || (err_q && !(wr_i && wdata_i[STS_ERR]));
      int_q <= irq_set_i || (int_q && !(wr_i && wdata_i[STS_INT]));
    end
  end

  always_comb begin
    sts_o          = '0;
    sts_o[STS_ACT] = active_i;
    sts_o[STS_ERR] = err_q;
    sts_o[STS_INT] = int_q;
  end
endmodule

// File: rtl/bm_base_reg.sv
module bm_base_reg
  import bm_dma_pkg::*;
#(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned ALIGN_BITS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [$clog2(DATA_W/8)-1:0] lane_off_i,
  input  logic [1:0]        size_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] base_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned LANES  = DATA_W / 8;
  localparam int unsigned LANE_W = $clog2(LANES);
  localparam int unsigned SH_W   = LANE_W + 3;

  logic [DATA_W-1:0] base_q, wmask, wdata_sh, mask_sh;
  logic [SH_W-1:0]   shift;

  always_comb begin
    wmask = '0;
    unique case (size_i)
      SZ_BYTE: wmask[7:0]  = '1;
      SZ_HALF: wmask[15:0] = '1;
      default: wmask       = '1;
    endcase
    shift    = {lane_off_i, 3'b000};
    wdata_sh = (wdata_i & wmask) << shift;
    mask_sh  = wmask << shift;
    rdata_o  = (base_q >> shift) & wmask;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [7:0] lane_d;
    if (l == 0) begin : g_low
      assign lane_d = {wdata_sh[7:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
    end else begin : g_hi
      assign lane_d = wdata_sh[8*l +: 8];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                   base_q[8*l +: 8] <= '0;
      else if (wr_i && mask_sh[8*l]) base_q[8*l +: 8] <= lane_d;
    end
  end

  assign base_o = base_q;
endmodule

// File: rtl/bm_dma_regs.sv
module bm_dma_regs
  import bm_dma_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_en_i,
  input  logic              acc_we_i,
  input  logic [2:0]        acc_off_i,
  input  logic [1:0]        acc_size_i,
  input  logic [DATA_W-1:0] acc_wdata_i,
  output logic [DATA_W-1:0] acc_rdata_o,
  input  logic              done_i,
  input  logic              err_i,
  input  logic              irq_i,
  output logic              irq_o,
  output logic              start_pulse_o,
  output logic              reload_o,
  output logic [DATA_W-1:0] table_base_o,
  output logic              dir_o,
  output logic              active_o
);
  localparam int unsigned LANE_W = $clog2(DATA_W / 8);

  logic       wr, cmd_wr, sts_wr, base_wr, in_base;
  logic [7:0] cmd_q, sts_q;
  logic [DATA_W-1:0] base_rd;

  assign wr      = acc_en_i && acc_we_i;
  assign in_base = acc_off_i[2];
  assign cmd_wr  = wr && (acc_off_i == OFF_CMD);
  assign sts_wr  = wr && (acc_off_i == OFF_STS);
  assign base_wr = wr && in_base;

  bm_cmd_ctrl u_cmd (
    .clk_i, .rst_ni,
    .wr_i          (cmd_wr),
    .wdata_i       (acc_wdata_i[7:0]),
    .done_i,
    .cmd_o         (cmd_q),
    .active_o,
    .start_pulse_o,
    .reload_o
  );

  bm_status_bits u_sts (
    .clk_i, .rst_ni,
    .wr_i      (sts_wr),
    .wdata_i   (acc_wdata_i[7:0]),
    .active_i  (active_o),
    .err_set_i (err_i),
    .irq_set_i (irq_i),
    .sts_o     (sts_q)
  );

  bm_base_reg #(.DATA_W(DATA_W)) u_base (
    .clk_i, .rst_ni,
    .wr_i       (base_wr),
    .lane_off_i (acc_off_i[LANE_W-1:0]),
    .size_i     (acc_size_i),
    .wdata_i    (acc_wdata_i),
    .base_o     (table_base_o),
    .rdata_o    (base_rd)
  );

  always_comb begin
    acc_rdata_o = '0;
    if (in_base)                    acc_rdata_o = base_rd;
    else if (acc_off_i == OFF_CMD)  acc_rdata_o[7:0] = cmd_q;
    else if (acc_off_i == OFF_STS)  acc_rdata_o[7:0] = sts_q;
  end

  assign dir_o = cmd_q[CMD_DIR];
  assign irq_o = irq_i;
endmodule

// File: rtl/bm_dma_regs_chk.sv
module bm_dma_regs_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              acc_en_i,
  input logic              acc_we_i,
  input logic [2:0]        acc_off_i,
  input logic [DATA_W-1:0] acc_wdata_i,
  input logic              done_i,
  input logic              irq_i,
  input logic              start_pulse_o,
  input logic              reload_o,
  input logic [DATA_W-1:0] table_base_o,
  input logic              active_o,
  input logic              run_bit,
  input logic              int_bit
);
  // R3
  same_run_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_en_i && acc_we_i && acc_off_i == 3'd0 && acc_wdata_i[0] == run_bit)
    |=> (!start_pulse_o && !reload_o));

  // R4
  start_has_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_pulse_o |-> (reload_o && active_o));

  // R4
  start_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_pulse_o |=> !start_pulse_o);

  // R6
  busy_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && !done_i) |=> active_o);

  // R6
  done_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && done_i) |=> !active_o);

  // R7
  base_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(acc_en_i && acc_we_i && acc_off_i[2]) |=> $stable(table_base_o));

  // R9
  irq_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |=> int_bit);
endmodule

bind bm_dma_regs bm_dma_regs_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i, .rst_ni, .acc_en_i, .acc_we_i, .acc_off_i, .acc_wdata_i,
  .done_i, .irq_i, .start_pulse_o, .reload_o, .table_base_o, .active_o,
  .run_bit (cmd_q[0]),
  .int_bit (sts_q[2])
);

// File: tb/bm_dma_regs_bench.sv
`timescale 1ns/100ps
module bm_dma_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_en = 1'b0, acc_we = 1'b0;
  logic [2:0]  acc_off = '0;
  logic [1:0]  acc_size = '0;
  logic [31:0] acc_wdata = '0;
  logic [31:0] acc_rdata;
  logic        done = 1'b0, err = 1'b0, irq = 1'b0;
  logic        irq_out, start_p, reload_p, dir, active;
  logic [31:0] tbase;

  int total = 0, bad = 0;
  logic finished = 1'b0;

  always #2.5 clk = ~clk;

  bm_dma_regs u_bm_dma_regs (
    .clk_i(clk), .rst_ni(rst_n), .acc_en_i(acc_en), .acc_we_i(acc_we),
    .acc_off_i(acc_off), .acc_size_i(acc_size), .acc_wdata_i(acc_wdata),
    .acc_rdata_o(acc_rdata), .done_i(done), .err_i(err), .irq_i(irq),
    .irq_o(irq_out), .start_pulse_o(start_p), .reload_o(reload_p),
    .table_base_o(tbase), .dir_o(dir), .active_o(active)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // after return: one edge has captured the write; sampled at the following negedge
  task automatic wr(input logic [2:0] off, input logic [1:0] sz, input logic [31:0] d);
    @(negedge clk);
    acc_en = 1'b1; acc_we = 1'b1; acc_off = off; acc_size = sz; acc_wdata = d;
    @(negedge clk);
    acc_en = 1'b0; acc_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] off, input logic [1:0] sz, output logic [31:0] d);
    @(negedge clk);
    acc_en = 1'b1; acc_we = 1'b0; acc_off = off; acc_size = sz;
    #1 d = acc_rdata;
    acc_en = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk); done = 1'b1;
    @(negedge clk); done = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(3'd0, 2'd0, d); check("R1 cmd", d, 32'h0);
    rd(3'd2, 2'd0, d); check("R1 sts", d, 32'h0);
    rd(3'd4, 2'd2, d); check("R1 base", d, 32'h0);
    check("R1 active", {31'b0, active}, 32'h0);
    check("R1 pulses", {30'b0, start_p, reload_p}, 32'h0);
  endtask

  task automatic t_cmd_bits();
    logic [31:0] d;
    wr(3'd0, 2'd0, 32'hFE);
    check("R3 no pulse on same run", {30'b0, start_p, reload_p}, 32'h0);
    rd(3'd0, 2'd0, d); check("R2 kept bits", d, 32'h08);
    check("R2 dir", {31'b0, dir}, 32'h1);
    wr(3'd0, 2'd0, 32'h00);
    check("R2 dir clear", {31'b0, dir}, 32'h0);
  endtask

  task automatic t_base();
    logic [31:0] d;
    wr(3'd4, 2'd2, 32'h12345677);
    rd(3'd4, 2'd2, d); check("R7 word low bits", d, 32'h12345674);
    wr(3'd5, 2'd0, 32'h000000AB);
    rd(3'd4, 2'd2, d); check("R7 byte lane1", d, 32'h1234AB74);
    wr(3'd6, 2'd1, 32'h0000CDEF);
    rd(3'd4, 2'd2, d); check("R7 half upper", d, 32'hCDEFAB74);
    wr(3'd4, 2'd0, 32'h000000FF);
    check("R7 base out", tbase, 32'hCDEFABFC);
    rd(3'd6, 2'd0, d); check("R8 byte read", d, 32'h000000EF);
    rd(3'd5, 2'd1, d); check("R8 half read", d, 32'h0000EFAB);
    rd(3'd7, 2'd0, d); check("R8 top byte", d, 32'h000000CD);
  endtask

  task automatic t_start_stop();
    logic [31:0] d;
    wr(3'd0, 2'd0, 32'h01);
    check("R4 pulses", {30'b0, start_p, reload_p}, 32'h3);
    check("R4 active", {31'b0, active}, 32'h1);
    @(negedge clk);
    check("R4 one cycle", {30'b0, start_p, reload_p}, 32'h0);
    wr(3'd0, 2'd0, 32'h01);
    check("R3 rewrite run", {30'b0, start_p, reload_p}, 32'h0);
    wr(3'd0, 2'd0, 32'h00);
    repeat (3) @(negedge clk);
    check("R6 stop holds busy", {31'b0, active}, 32'h1);
    wr(3'd0, 2'd0, 32'h01);
    check("R5 reload only", {30'b0, start_p, reload_p}, 32'h1);
    wr(3'd2, 2'd0, 32'hFF);
    rd(3'd2, 2'd0, d); check("R10 busy read-only", d[0], 32'h1);
    wr(3'd0, 2'd0, 32'h00);
    pulse_done();
    check("R6 done clears", {31'b0, active}, 32'h0);
    rd(3'd2, 2'd0, d); check("R6 sts bit0", d, 32'h0);
  endtask

  task automatic t_status();
    logic [31:0] d;
    @(negedge clk); irq = 1'b1; #1;
    check("R9 pass high", {31'b0, irq_out}, 32'h1);
    @(negedge clk); irq = 1'b0; #1;
    check("R9 pass low", {31'b0, irq_out}, 32'h0);
    rd(3'd2, 2'd0, d); check("R9 int sticky", d, 32'h04);
    @(negedge clk); err = 1'b1;
    @(negedge clk); err = 1'b0;
    rd(3'd2, 2'd0, d); check("R10 err set", d, 32'h06);
    wr(3'd2, 2'd0, 32'h04);
    rd(3'd2, 2'd0, d); check("R10 clear int only", d, 32'h02);
    wr(3'd2, 2'd0, 32'h02);
    rd(3'd2, 2'd0, d); check("R10 clear err", d, 32'h00);
    @(negedge clk); irq = 1'b1;
    wr(3'd2, 2'd0, 32'h04);
    irq = 1'b0;
    rd(3'd2, 2'd0, d); check("R11 set beats clear", d, 32'h04);
    wr(3'd2, 2'd0, 32'h04);
  endtask

  task automatic t_reset_mid();
    logic [31:0] d;
    wr(3'd4, 2'd2, 32'hA5A5A5A4);
    wr(3'd0, 2'd0, 32'h09);
    @(negedge clk); rst_n = 1'b0; #1;
    check("R1 reset cancels busy", {31'b0, active}, 32'h0);
    check("R1 reset base", tbase, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    rd(3'd0, 2'd0, d); check("R1 reset cmd", d, 32'h0);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_cmd_bits();
    t_base();
    t_start_stop();
    t_status();
    t_reset_mid();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule